// File: doc/BRIEF.md
# Current-Sense ADC Offset Calibration Sequencer

This block performs the start-up offset calibration of the two current-measuring inputs of an ADC core. On request it drives the core's control registers through a masked-write and read register port. For each channel it runs calibration conversions in pairs and reads the 10-bit offset sample after every conversion. It keeps the second sample of a pair when the pair is stable and lies in the expected window. From that sample it derives a signed correction, equal to the midpoint minus the sample, and keeps it for that channel.

Each attempt is made of two conversions. A failed attempt is followed by a back-off time measured in microsecond ticks, and after a fixed number of failed attempts the channel is given up and flagged. A vendor-bypass input makes the first attempt pass whatever it reads. The charge-current channel (bank position 5) is calibrated before the system-current channel (bank position 6). A single channel can also be requested on its own. Requests naming any other position are dropped.

Top module: `ofs_cal_ctrl`

## Requirements
- R1: A request with `cal_all`=0 whose `cal_chan` is neither 5 nor 6 is ignored: no bus access, `busy` stays 0 and no `cal_done` follows.
- R2: One calibration conversion issues four masked writes in this order. First, control word 1 gets bit 14 (calibration mode) and bit 1 (random select) set, with the channel position in bits 6:4 and bits 13:7, 3 and 2 cleared. Next, control word 2 has bits 11:9 cleared. Then bit 5 of control word 2 is set. Last, bit 12 of control word 2 (start) is set.
- R3: After the start write, control word 2 is read repeatedly until bit 12 reads 0. If the bit still reads 1 once `POLL_LIMIT_US` ticks have passed since the start write, `poll_timeout` pulses for one cycle. In both cases bit 14 of control word 1 is cleared before the offset register is read.
- R4: Each attempt runs two conversions back to back and reads the channel's offset register (low 10 bits) after each one.
- R5: An attempt passes when the second sample lies in 494..530 inclusive and the two samples differ by at most 3.
- R6: With `vendor_bypass` high at the request, the first attempt of each channel passes unconditionally.
- R7: On a pass, the channel's offset output becomes 512 minus the second sample, as an 11-bit two's-complement value.
- R8: A channel gets at most 5 attempts, and a failed attempt is followed by a wait of at least `RETRY_WAIT_US` ticks before the next one starts.
- R9: With `cal_all`=1 the charge channel (position 5) is calibrated completely before the system channel (position 6).
- R10: When all attempts fail, the channel's offset keeps its previous value (0 after reset) and its fail flag is set. A later pass clears the flag.
- R11: `cal_done` is a one-cycle pulse issued once, after every requested channel has finished, pass or fail.
- R12: With `cal_all`=0 and `cal_chan` equal to 5 or 6, only that channel is converted and the other channel's outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cal_go | input | 1 | Request pulse, taken while idle |
| cal_all | input | 1 | 1: both channels in order; 0: the channel in `cal_chan` |
| cal_chan | input | 3 | Bank position for a single-channel request |
| vendor_bypass | input | 1 | First attempt passes unconditionally |
| bus_wr | output | 1 | Masked register write strobe |
| bus_rd | output | 1 | Register read strobe; data is expected the next cycle |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_wmask | output | DATA_W | Bits of the register that the write changes |
| bus_rdata | input | DATA_W | Read data, valid the cycle after `bus_rd` |
| busy | output | 1 | Sequence in progress |
| cal_done | output | 1 | One-cycle completion pulse |
| poll_timeout | output | 1 | One-cycle pulse when a conversion poll expires |
| ofs_chg | output | SAMPLE_W+1 | Signed correction, charge-current channel |
| ofs_sys | output | SAMPLE_W+1 | Signed correction, system-current channel |
| fail_chg | output | 1 | Charge channel exhausted its attempts |
| fail_sys | output | 1 | System channel exhausted its attempts |

## Verification
Two events can land in the same poll-check cycle: the ADC core clearing the start bit, and the poll timer reaching its limit. When both happen in that cycle, the completion must win. The bench's core model lets a test choose its conversion latency. One run finishes each conversion exactly at the last read that the limit still allows, and another finishes one tick later. The bench judges the outcome by the number of `poll_timeout` pulses, which must be zero in the first run and one per conversion in the second, while the stored offsets stay correct in both runs.

// File: rtl/ofscal_pkg.sv
package ofscal_pkg;

   // control word 1 fields
   localparam int CW1_CALMODE = 14;
   localparam int CW1_RSEL    = 1;
   localparam int CW1_CH_LO   = 4;
   // control word 2 fields
   localparam int CW2_START   = 12;
   localparam int CW2_PS_HI   = 11;
   localparam int CW2_PS_LO   = 9;
   localparam int CW2_TRIGOFF = 5;

   localparam logic [2:0] CH_CHG = 3'd5;
   localparam logic [2:0] CH_SYS = 3'd6;

   typedef enum logic [3:0] {
      ST_IDLE, ST_MODE, ST_PRESC, ST_TRIGOFF, ST_START,
      ST_POLL_RD, ST_POLL_CHK, ST_MODE_CLR, ST_SAMP_RD, ST_SAMP_CAP,
      ST_JUDGE, ST_BACKOFF, ST_NEXT
   } ofs_state_e;

endpackage

// File: rtl/ofscal_ticker.sv
module ofscal_ticker #(
   parameter int SAT = 1000,
   localparam int CNT_W = $clog2(SAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

   generate
      if (SAT < 1) begin : g_bad_sat
         $error("ofscal_ticker: SAT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                    count <= '0;
      else if (clr)                  count <= '0;
      else if (tick && count != SAT_V) count <= count + 1'b1;
   end

   // R8
   ticker_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1));

endmodule

// File: rtl/ofscal_accept.sv
module ofscal_accept #(
   parameter int SAMPLE_W = 10,
   parameter int WIN_LO   = 494,
   parameter int WIN_HI   = 530,
   parameter int MAX_DIFF = 3,
   parameter int MIDPOINT = 512,
   localparam int OFS_W   = SAMPLE_W + 1
) (
   input  logic [SAMPLE_W-1:0]    s_first,
   input  logic [SAMPLE_W-1:0]    s_second,
   input  logic                   force_ok,
   output logic                   ok,
   output logic signed [OFS_W-1:0] ofs
);
   generate
      if (WIN_HI >= (1 << SAMPLE_W) || WIN_LO > WIN_HI) begin : g_bad_win
         $error("ofscal_accept: window does not fit the sample width");
      end
      if (MIDPOINT >= (1 << SAMPLE_W)) begin : g_bad_mid
         $error("ofscal_accept: midpoint does not fit the sample width");
      end
   endgenerate

   logic [SAMPLE_W-1:0] gap;
   logic                in_win;

   always_comb begin
      gap    = (s_first > s_second) ? (s_first - s_second) : (s_second - s_first);
      in_win = (s_second >= SAMPLE_W'(WIN_LO)) && (s_second <= SAMPLE_W'(WIN_HI));
      ok     = force_ok || (in_win && (gap <= SAMPLE_W'(MAX_DIFF)));
      ofs    = $signed(OFS_W'(MIDPOINT) - OFS_W'(s_second));
   end

endmodule

// File: rtl/ofscal_slot.sv
module ofscal_slot #(
   parameter int OFS_W = 11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   take,
   input  logic                   miss,
   input  logic signed [OFS_W-1:0] ofs_in,
   output logic signed [OFS_W-1:0] ofs_out,
   output logic                   fail_out
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_out  <= '0;
         fail_out <= 1'b0;
      end else if (take) begin
         ofs_out  <= ofs_in;
         fail_out <= 1'b0;
      end else if (miss) begin
         fail_out <= 1'b1;
      end
   end

   // R10
   slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss && !take) |=> (ofs_out == $past(ofs_out)) && fail_out);

endmodule

// File: rtl/ofs_cal_ctrl.sv
module ofs_cal_ctrl
   import ofscal_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter int CW1_ADDR      = 8'h00,
   parameter int CW2_ADDR      = 8'h01,
   parameter int CHG_CAL_ADDR  = 8'h02,
   parameter int SYS_CAL_ADDR  = 8'h03,
   parameter int SAMPLE_W      = 10,
   parameter int MAX_TRIES     = 5,
   parameter int WIN_LO        = 494,
   parameter int WIN_HI        = 530,
   parameter int MAX_DIFF      = 3,
   parameter int MIDPOINT      = 512,
   parameter int POLL_LIMIT_US = 3000000,
   parameter int RETRY_WAIT_US = 5000,
   localparam int OFS_W        = SAMPLE_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    us_tick,
   input  logic                    cal_go,
   input  logic                    cal_all,
   input  logic [2:0]              cal_chan,
   input  logic                    vendor_bypass,
   output logic                    bus_wr,
   output logic                    bus_rd,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_wmask,
   input  logic [DATA_W-1:0]       bus_rdata,
   output logic                    busy,
   output logic                    cal_done,
   output logic                    poll_timeout,
   output logic signed [OFS_W-1:0] ofs_chg,
   output logic signed [OFS_W-1:0] ofs_sys,
   output logic                    fail_chg,
   output logic                    fail_sys
);
   localparam int TMR_SAT = (POLL_LIMIT_US > RETRY_WAIT_US) ? POLL_LIMIT_US : RETRY_WAIT_US;
   localparam int TMR_W   = $clog2(TMR_SAT + 1);
   localparam int ATT_W   = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
   localparam logic [TMR_W-1:0] POLL_LIM  = TMR_W'(POLL_LIMIT_US);
   localparam logic [TMR_W-1:0] WAIT_LIM  = TMR_W'(RETRY_WAIT_US);
   localparam logic [ATT_W-1:0] LAST_TRY  = ATT_W'(MAX_TRIES - 1);
   localparam int N_CH = 2;

   generate
      if (DATA_W < 16) begin : g_bad_data
         $error("ofs_cal_ctrl: control fields need DATA_W of at least 16");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("ofs_cal_ctrl: MAX_TRIES must be at least 1");
      end
      if (SAMPLE_W > DATA_W) begin : g_bad_sample
         $error("ofs_cal_ctrl: sample wider than the data bus");
      end
   endgenerate

   ofs_state_e          st_q;
   logic                chan_q, both_q, byp_q, second_q;
   logic [ATT_W-1:0]    att_q;
   logic [SAMPLE_W-1:0] s0_q, s1_q;
   logic                done_q, tmo_q;
   logic [TMR_W-1:0]    tmr;
   logic                tmr_clr;
   logic                acc_ok;
   logic signed [OFS_W-1:0] acc_ofs;
   logic [N_CH-1:0]     take, miss;
   logic signed [OFS_W-1:0] slot_ofs [N_CH];
   logic [N_CH-1:0]     slot_fail;
   logic [2:0]          cur_ch;
   logic                go_ok;
   logic                unused_rdata;

   assign unused_rdata = ^bus_rdata;
   assign cur_ch  = chan_q ? CH_SYS : CH_CHG;
   assign go_ok   = cal_go && (cal_all || cal_chan == CH_CHG || cal_chan == CH_SYS);
   assign tmr_clr = (st_q == ST_START) || (st_q == ST_JUDGE);

   ofscal_ticker #(.SAT(TMR_SAT)) u_ticker (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(us_tick), .count(tmr)
   );

   ofscal_accept #(
      .SAMPLE_W(SAMPLE_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
      .MAX_DIFF(MAX_DIFF), .MIDPOINT(MIDPOINT)
   ) u_accept (
      .s_first(s0_q), .s_second(s1_q),
      .force_ok(byp_q && (att_q == '0)),
      .ok(acc_ok), .ofs(acc_ofs)
   );

   always_comb begin
      take = '0;
      miss = '0;
      if (st_q == ST_JUDGE) begin
         if (acc_ok)                 take[chan_q] = 1'b1;
         else if (att_q == LAST_TRY) miss[chan_q] = 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_slot
         ofscal_slot #(.OFS_W(OFS_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .take(take[g]), .miss(miss[g]),
            .ofs_in(acc_ofs), .ofs_out(slot_ofs[g]), .fail_out(slot_fail[g])
         );
      end
   endgenerate

   assign ofs_chg  = slot_ofs[0];
   assign ofs_sys  = slot_ofs[1];
   assign fail_chg = slot_fail[0];
   assign fail_sys = slot_fail[1];

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         chan_q   <= 1'b0;
         both_q   <= 1'b0;
         byp_q    <= 1'b0;
         second_q <= 1'b0;
         att_q    <= '0;
         s0_q     <= '0;
         s1_q     <= '0;
         done_q   <= 1'b0;
         tmo_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         case (st_q)
            ST_IDLE: if (go_ok) begin
               both_q   <= cal_all;
               chan_q   <= !cal_all && (cal_chan == CH_SYS);
               byp_q    <= vendor_bypass;
               att_q    <= '0;
               second_q <= 1'b0;
               st_q     <= ST_MODE;
            end
            ST_MODE:    st_q <= ST_PRESC;
            ST_PRESC:   st_q <= ST_TRIGOFF;
            ST_TRIGOFF: st_q <= ST_START;
            ST_START:   st_q <= ST_POLL_RD;
            ST_POLL_RD: st_q <= ST_POLL_CHK;
            ST_POLL_CHK: begin
               if (!bus_rdata[CW2_START]) begin
                  st_q <= ST_MODE_CLR;
               end else if (tmr >= POLL_LIM) begin
                  tmo_q <= 1'b1;
                  st_q  <= ST_MODE_CLR;
               end else begin
                  st_q <= ST_POLL_RD;
               end
            end
            ST_MODE_CLR: st_q <= ST_SAMP_RD;
            ST_SAMP_RD:  st_q <= ST_SAMP_CAP;
            ST_SAMP_CAP: begin
               if (!second_q) begin
                  s0_q     <= bus_rdata[SAMPLE_W-1:0];
                  second_q <= 1'b1;
                  st_q     <= ST_MODE;
               end else begin
                  s1_q     <= bus_rdata[SAMPLE_W-1:0];
                  second_q <= 1'b0;
                  st_q     <= ST_JUDGE;
               end
            end
            ST_JUDGE: begin
               if (acc_ok || att_q == LAST_TRY) begin
                  st_q <= ST_NEXT;
               end else begin
                  att_q <= att_q + 1'b1;
                  st_q  <= ST_BACKOFF;
               end
            end
            ST_BACKOFF: if (tmr >= WAIT_LIM) st_q <= ST_MODE;
            ST_NEXT: begin
               att_q <= '0;
               if (both_q && !chan_q) begin
                  chan_q <= 1'b1;
                  st_q   <= ST_MODE;
               end else begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // register port decode
   always_comb begin
      bus_wr    = 1'b0;
      bus_rd    = 1'b0;
      bus_addr  = ADDR_W'(CW1_ADDR);
      bus_wdata = '0;
      bus_wmask = '0;
      case (st_q)
         ST_MODE: begin
            bus_wr = 1'b1;
            bus_wmask[CW1_CALMODE:CW1_RSEL] = '1;
            bus_wdata[CW1_CALMODE]          = 1'b1;
            bus_wdata[CW1_RSEL]             = 1'b1;
            bus_wdata[CW1_CH_LO +: 3]       = cur_ch;
         end
         ST_PRESC: begin
            bus_wr   = 1'b1;
            bus_addr = ADDR_W'(CW2_ADDR);
            bus_wmask[CW2_PS_HI:CW2_PS_LO] = '1;
         end
         ST_TRIGOFF: begin
            bus_wr   = 1'b1;
            bus_addr = ADDR_W'(CW2_ADDR);
            bus_wmask[CW2_TRIGOFF] = 1'b1;
            bus_wdata[CW2_TRIGOFF] = 1'b1;
         end
         ST_START: begin
            bus_wr   = 1'b1;
            bus_addr = ADDR_W'(CW2_ADDR);
            bus_wmask[CW2_START] = 1'b1;
            bus_wdata[CW2_START] = 1'b1;
         end
         ST_POLL_RD: begin
            bus_rd   = 1'b1;
            bus_addr = ADDR_W'(CW2_ADDR);
         end
         ST_MODE_CLR: begin
            bus_wr = 1'b1;
            bus_wmask[CW1_CALMODE] = 1'b1;
         end
         ST_SAMP_RD: begin
            bus_rd   = 1'b1;
            bus_addr = chan_q ? ADDR_W'(SYS_CAL_ADDR) : ADDR_W'(CHG_CAL_ADDR);
         end
         default: ;
      endcase
   end

   assign busy         = (st_q != ST_IDLE);
   assign cal_done     = done_q;
   assign poll_timeout = tmo_q;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done);

   // R1
   ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cal_go && !cal_all && cal_chan != CH_CHG && cal_chan != CH_SYS) |=> !busy);

   // R3
   start_then_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CW2_ADDR) && bus_wmask[CW2_START] && bus_wdata[CW2_START])
      |=> (bus_rd && bus_addr == ADDR_W'(CW2_ADDR)));

   // R2
   mode_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CW1_ADDR) && bus_wdata[CW1_CALMODE])
      |-> (bus_wdata[CW1_CH_LO +: 3] == CH_CHG || bus_wdata[CW1_CH_LO +: 3] == CH_SYS));

   // R8
   try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      att_q <= LAST_TRY);

endmodule

// File: tb/ofs_cal_ctrl_bench.sv
module ofs_cal_ctrl_bench;
   localparam int POLL_LIM = 41;
   localparam int RWAIT    = 30;
   localparam logic [7:0] A_CW1 = 8'h00, A_CW2 = 8'h01, A_CHG = 8'h02, A_SYS = 8'h03;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b1;
   logic cal_go = 1'b0, cal_all = 1'b0, vendor_bypass = 1'b0;
   logic [2:0] cal_chan = 3'd0;
   logic bus_wr, bus_rd;
   logic [7:0] bus_addr;
   logic [15:0] bus_wdata, bus_wmask, rdata;
   logic busy, cal_done, poll_timeout, fail_chg, fail_sys;
   logic signed [10:0] ofs_chg, ofs_sys;

   always #10 clk = ~clk;

   ofs_cal_ctrl #(.POLL_LIMIT_US(POLL_LIM), .RETRY_WAIT_US(RWAIT)) u_ofs_cal_ctrl (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cal_go(cal_go), .cal_all(cal_all),
      .cal_chan(cal_chan), .vendor_bypass(vendor_bypass), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(rdata),
      .busy(busy), .cal_done(cal_done), .poll_timeout(poll_timeout),
      .ofs_chg(ofs_chg), .ofs_sys(ofs_sys), .fail_chg(fail_chg), .fail_sys(fail_sys)
   );

   int n_chk = 0, n_err = 0;

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // ADC core model
   int cyc = 0;
   logic [15:0] m_c1, m_c2, m_cal_chg, m_cal_sys;
   int m_busy = 0, m_lat = 6, m_ch = 0;
   int m_wrs = 0, m_convs = 0, m_conv_chg = 0, m_conv_sys = 0, m_first = 0;
   int m_fmt_err = 0, m_mode_err = 0;
   int q_chg[$], q_sys[$], start_cyc[$];

   function automatic logic [15:0] pop_smp(inout int q[$]);
      if (q.size() == 0) return 16'd512;
      return 16'(q.pop_front());
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_c1 = 16'h1004; m_c2 = 16'h0E00; m_busy = 0;
         m_cal_chg = 16'd512; m_cal_sys = 16'd512;
         rdata <= 16'h0;
      end else begin
         if (bus_rd) begin
            case (bus_addr)
               A_CW1:   rdata <= m_c1;
               A_CW2:   rdata <= m_c2;
               A_CHG:   rdata <= m_cal_chg;
               A_SYS:   rdata <= m_cal_sys;
               default: rdata <= 16'h0;
            endcase
            if ((bus_addr == A_CHG || bus_addr == A_SYS) && m_c1[14]) m_mode_err++;
         end
         if (m_busy > 0) begin
            if (m_busy == 1) begin
               m_c2[12] = 1'b0;
               if (m_ch == 5) m_cal_chg = pop_smp(q_chg);
               else           m_cal_sys = pop_smp(q_sys);
            end
            m_busy--;
         end
         if (bus_wr) begin
            m_wrs++;
            if (bus_addr == A_CW1) begin
               m_c1 = (m_c1 & ~bus_wmask) | (bus_wdata & bus_wmask);
            end else if (bus_addr == A_CW2) begin
               if (bus_wmask[12] && bus_wdata[12]) begin
                  if (!(m_c1[14] && m_c1[1] && m_c1[13:7] == 7'd0 && m_c1[3:2] == 2'd0 &&
                        m_c2[11:9] == 3'd0 && m_c2[5])) m_fmt_err++;
                  m_ch = int'(m_c1[6:4]);
                  if (m_convs == 0) m_first = m_ch;
                  m_convs++;
                  if (m_ch == 5) m_conv_chg++;
                  if (m_ch == 6) m_conv_sys++;
                  start_cyc.push_back(cyc);
                  m_busy = m_lat;
               end
               m_c2 = (m_c2 & ~bus_wmask) | (bus_wdata & bus_wmask);
            end
         end
      end
   end

   // scoreboard
   typedef struct {
      string tag;
      int ofs_c, ofs_s, fl_c, fl_s, cv_c, cv_s, tmo, first;
   } exp_t;
   exp_t exp_q[$];
   int tmo_cnt = 0, done_cnt = 0;
   bit done_seen = 0;
   int prev_c = 0, prev_s = 0, prev_fc = 0, prev_fs = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (poll_timeout) tmo_cnt++;
         if (cal_done) begin
            done_seen = 1;
            done_cnt++;
            if (exp_q.size() == 0) chk("R11 unexpected done", 1, 0);
            else begin
               exp_t it;
               it = exp_q.pop_front();
               chk({"R7 ofs_chg ", it.tag}, int'(ofs_chg), it.ofs_c);
               chk({"R7 ofs_sys ", it.tag}, int'(ofs_sys), it.ofs_s);
               chk({"R10 fail_chg ", it.tag}, int'(fail_chg), it.fl_c);
               chk({"R10 fail_sys ", it.tag}, int'(fail_sys), it.fl_s);
               chk({"R4 conv_chg ", it.tag}, m_conv_chg, it.cv_c);
               chk({"R12 conv_sys ", it.tag}, m_conv_sys, it.cv_s);
               chk({"R3 timeouts ", it.tag}, tmo_cnt, it.tmo);
               chk({"R9 first channel ", it.tag}, m_first, it.first);
            end
         end
      end
   end

   function automatic void judge(input int s[10], input bit byp,
                                 inout int ofs, inout int fl, output int cv);
      cv = 0;
      fl = 1;
      for (int a = 0; a < 5; a++) begin
         int x0 = s[2*a];
         int x1 = s[2*a+1];
         int d  = (x0 > x1) ? x0 - x1 : x1 - x0;
         cv += 2;
         if ((byp && a == 0) || (x1 >= 494 && x1 <= 530 && d <= 3)) begin
            ofs = 512 - x1;
            fl  = 0;
            break;
         end
      end
   endfunction

   task automatic run_cal(input string tag, input bit all, input int ch, input bit byp,
                          input int lat, input int sc[10], input int ss[10]);
      exp_t it;
      int cvc = 0, cvs = 0;
      q_chg.delete(); q_sys.delete(); start_cyc.delete();
      foreach (sc[i]) q_chg.push_back(sc[i]);
      foreach (ss[i]) q_sys.push_back(ss[i]);
      m_convs = 0; m_conv_chg = 0; m_conv_sys = 0; tmo_cnt = 0; done_seen = 0; m_lat = lat;
      if (all || ch == 5) judge(sc, byp, prev_c, prev_fc, cvc);
      if (all || ch == 6) judge(ss, byp, prev_s, prev_fs, cvs);
      it.tag = tag;
      it.ofs_c = prev_c; it.ofs_s = prev_s; it.fl_c = prev_fc; it.fl_s = prev_fs;
      it.cv_c = cvc; it.cv_s = cvs;
      it.tmo = (lat >= POLL_LIM) ? cvc + cvs : 0;
      it.first = (all || ch == 5) ? 5 : 6;
      exp_q.push_back(it);
      @(negedge clk);
      cal_go = 1'b1; cal_all = all; cal_chan = 3'(ch); vendor_bypass = byp;
      @(negedge clk);
      cal_go = 1'b0; vendor_bypass = 1'b0;
      for (int i = 0; i < 20000 && !done_seen; i++) @(negedge clk);
      chk({"R11 done seen ", tag}, int'(done_seen), 1);
      @(negedge clk);
      chk({"R11 busy after done ", tag}, int'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R11 reset busy", int'(busy), 0);
      chk("R11 reset done", int'(cal_done), 0);
      chk("R10 reset ofs_chg", int'(ofs_chg), 0);
      chk("R10 reset ofs_sys", int'(ofs_sys), 0);
      chk("R10 reset fails", int'(fail_chg) + int'(fail_sys), 0);
      chk("R2 reset bus idle", int'(bus_wr) + int'(bus_rd), 0);

      // R1: non-current positions are dropped
      cal_go = 1'b1; cal_all = 1'b0; cal_chan = 3'd3;
      @(negedge clk);
      cal_chan = 3'd7;
      @(negedge clk);
      cal_go = 1'b0;
      repeat (40) @(negedge clk);
      chk("R1 no bus writes", m_wrs, 0);
      chk("R1 not busy", int'(busy), 0);
      chk("R1 no done", done_cnt, 0);

      // R5 R7 R9: both pass first try
      run_cal("basic", 1, 0, 0, 6, '{505,507,0,0,0,0,0,0,0,0}, '{530,528,0,0,0,0,0,0,0,0});
      // R4 R5 R8: retries, window low edge with gap 3
      run_cal("retry", 1, 0, 0, 6, '{600,601,500,505,498,496,0,0,0,0},
                                   '{491,494,0,0,0,0,0,0,0,0});
      chk("R8 backoff gap", int'((start_cyc[2] - start_cyc[1]) > RWAIT), 1);
      chk("R8 no wait inside attempt", int'((start_cyc[1] - start_cyc[0]) < RWAIT), 1);
      // R8 R10: exhaustion on the charge channel
      run_cal("exhaust", 1, 0, 0, 6, '{520,531,493,493,600,600,510,514,0,0},
                                     '{530,527,0,0,0,0,0,0,0,0});
      // R10 R12: single charge request clears the flag
      run_cal("single5", 0, 5, 0, 6, '{511,512,0,0,0,0,0,0,0,0}, '{0,0,0,0,0,0,0,0,0,0});
      // R6: bypass accepts out-of-window samples, extreme offsets
      run_cal("bypass", 1, 0, 1, 6, '{700,100,0,0,0,0,0,0,0,0}, '{0,1023,0,0,0,0,0,0,0,0});
      // R3: completion on the last allowed poll vs one tick late
      run_cal("edge40", 0, 6, 0, 40, '{0,0,0,0,0,0,0,0,0,0}, '{512,512,0,0,0,0,0,0,0,0});
      run_cal("edge41", 0, 6, 0, 41, '{0,0,0,0,0,0,0,0,0,0}, '{500,501,0,0,0,0,0,0,0,0});

      chk("R2 control field format", m_fmt_err, 0);
      chk("R3 mode cleared before offset read", m_mode_err, 0);
      chk("R11 done pulses", done_cnt, 7);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule